// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It divides its input clock by N = B·P + A. Inside it, a prescaler counts input cycles in groups of P+1 or P. A swallow count A chooses which modulus applies, and a main count B sets how many prescaler groups make up one output period. P is picked from 8, 16, 32 and 64 by a 2-bit select. Any ratio whose A lies between 0 and B can be reached this way, which a single fixed-ratio counter cannot do.

New settings are presented on `psel`, `a_val` and `b_val` and captured on a one-cycle `load` strobe into a holding stage. A running divider applies the held settings only when its current output period ends, so no period is ever cut short. The output `div_out` is a single-cycle pulse once per N input cycles, meant for a phase detector. An illegal setting parks the block in a fault state with the output silent until a legal setting is loaded.

The control is a four-state machine. IDLE is entered at reset and waits for the first load. SWALLOW counts prescaler groups of P+1. MAIN counts groups of P. FAULT holds the output low. The transitions are:
- *launch* from IDLE or FAULT when fresh settings are held;
- *swallow-done* from SWALLOW to MAIN when the last swallow group completes;
- *wrap* from SWALLOW or MAIN when the final main group completes.

Both launch and wrap go to SWALLOW if A > 0, to MAIN if A = 0, and to FAULT if the settings are illegal.

Top module: `pswallow_div`

## Requirements
- R1: The interval between consecutive `div_out` pulses is exactly N = B·P + A input clock cycles.
- R2: `psel` selects P with the encoding 00 → 8, 01 → 16, 10 → 32, 11 → 64; the other modulus of the pair is P+1.
- R3: A is a 6-bit value (0..63) and B a 13-bit value; every A and B that satisfies R7 gives the ratio of R1, including A = 63 and B ≥ 1000.
- R4: Within a period the prescaler counts groups of P+1 for the first A groups and groups of P for the remaining B−A; A = 0 and A = B both give the ratio of R1.
- R5: Settings loaded while the divider runs leave the current period unchanged; they take effect from the period that starts at the next wrap.
- R6: `div_out` is high for exactly one input clock cycle per period.
- R7: A setting with A > B or B = 0 drives `cfg_err` high and keeps `div_out` low for as long as the fault persists. A later legal load clears `cfg_err` and restarts division with the latency of R8. If an illegal setting is loaded mid-period, that period still ends with its pulse and `cfg_err` rises in the same cycle.
- R8: After reset `div_out` and `cfg_err` are low and nothing happens until a load. When a load is captured at clock edge k from IDLE or FAULT, the first pulse appears after edge k+1+N.
- R9: If several loads occur within one period, the settings of the last one are the ones applied at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (RF-rate) clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures psel, a_val and b_val |
| psel | input | 2 | Prescaler select (00:8, 01:16, 10:32, 11:64) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_out | output | 1 | Divided output, one-cycle pulse per N input cycles |
| cfg_err | output | 1 | High while the held settings are illegal |

## Verification
The bench drives every input and samples every output on the falling clock edge, so each capture edge lies half a cycle after a stimulus. Timing is counted in falling edges.
- **First pulse.** After a load captured from IDLE or FAULT, the first pulse is due on the (N+1)-th falling edge.
- **Steady running.** Each later pulse is due exactly N falling edges after the previous one. The falling edge right after a pulse must see the output low.
- **Mid-period loads.** When settings change mid-period, the falling edges already spent issuing the loads are added back in. The period in flight must then still measure the old N, and the one after it the new N.
- **Fault flag.** `cfg_err` is due one falling edge after the capture of an illegal setting from IDLE or FAULT. It is due on the same falling edge as the final pulse when the illegal setting was loaded mid-run.

// File: rtl/swd_pkg.sv
package swd_pkg;

    // Smallest prescaler modulus; psel shifts it left by 0..3
    localparam int unsigned PRE_BASE = 8;
    localparam int unsigned PSEL_W   = 2;
    localparam int unsigned PCNT_W   = 7;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_FAULT   = 2'd3
    } swd_state_e;

    // Terminal value of the prescaler count: P-1 for modulus P, P for P+1
    function automatic logic [PCNT_W-1:0] pre_top(input logic [PSEL_W-1:0] sel,
                                                  input logic plus1);
        logic [PCNT_W-1:0] base;
        base = PCNT_W'(PRE_BASE) << sel;
        return plus1 ? base : base - PCNT_W'(1);
    endfunction

endpackage

// File: rtl/swd_cfg_hold.sv
module swd_cfg_hold
    import swd_pkg::*;
#(
    parameter int unsigned A_W = 6,
    parameter int unsigned B_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PSEL_W-1:0] psel_in,
    input  logic [A_W-1:0]    a_in,
    input  logic [B_W-1:0]    b_in,
    input  logic              taken,
    output logic [PSEL_W-1:0] pend_psel,
    output logic [A_W-1:0]    pend_a,
    output logic [B_W-1:0]    pend_b,
    output logic              pend_new,
    output logic              pend_legal
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_psel <= '0;
            pend_a    <= '0;
            pend_b    <= '0;
            pend_new  <= 1'b0;
        end else if (load) begin
            pend_psel <= psel_in;
            pend_a    <= a_in;
            pend_b    <= b_in;
            pend_new  <= 1'b1;
        end else if (taken) begin
            pend_new  <= 1'b0;
        end
    end

    always_comb begin
        pend_legal = (pend_b != '0) && (B_W'(pend_a) <= pend_b);
    end

endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              plus1,
    input  logic [PSEL_W-1:0] sel,
    output logic              wrap,
    output logic [PCNT_W-1:0] cnt
);

    logic [PCNT_W-1:0] top;

    always_comb begin
        top  = pre_top(sel, plus1);
        wrap = run && (cnt == top);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PCNT_W'(1);
        end
    end

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
    import swd_pkg::*;
#(
    parameter int unsigned A_W = 6,
    parameter int unsigned B_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_wrap,
    input  logic [PSEL_W-1:0] pend_psel,
    input  logic [A_W-1:0]    pend_a,
    input  logic [B_W-1:0]    pend_b,
    input  logic              pend_new,
    input  logic              pend_legal,
    output swd_state_e        state,
    output logic [PSEL_W-1:0] act_psel,
    output logic [A_W-1:0]    a_left,
    output logic [B_W-1:0]    b_left,
    output logic              taken,
    output logic              div_out,
    output logic              cfg_err
);

    swd_state_e state_n;
    swd_state_e launch;
    logic       running;
    logic       term;

    always_comb begin
        running = (state == ST_SWALLOW) || (state == ST_MAIN);
        term    = running && pre_wrap && (b_left == B_W'(1));
        taken   = term || (!running && pend_new);
        if (!pend_legal) begin
            launch = ST_FAULT;
        end else if (pend_a != '0) begin
            launch = ST_SWALLOW;
        end else begin
            launch = ST_MAIN;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_FAULT: begin
                if (pend_new) state_n = launch;
            end
            ST_SWALLOW: begin
                if (term) begin
                    state_n = launch;
                end else if (pre_wrap && (a_left == A_W'(1))) begin
                    state_n = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (term) state_n = launch;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // Period counters and applied prescaler select
    always_ff @(posedge clk) begin
        if (rst) begin
            act_psel <= '0;
            a_left   <= '0;
            b_left   <= '0;
        end else if (taken) begin
            act_psel <= pend_psel;
            a_left   <= pend_a;
            b_left   <= pend_b;
        end else if (running && pre_wrap) begin
            b_left <= b_left - B_W'(1);
            if (state == ST_SWALLOW) a_left <= a_left - A_W'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            div_out <= term;
            cfg_err <= (state_n == ST_FAULT);
        end
    end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import swd_pkg::*;
#(
    parameter int unsigned A_W = 6,
    parameter int unsigned B_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PSEL_W-1:0] psel,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    output logic              div_out,
    output logic              cfg_err
);

    logic [PSEL_W-1:0] pend_psel;
    logic [A_W-1:0]    pend_a;
    logic [B_W-1:0]    pend_b;
    logic              pend_new;
    logic              pend_legal;
    logic              taken;
    swd_state_e        state;
    logic [PSEL_W-1:0] act_psel;
    logic [A_W-1:0]    a_left;
    logic [B_W-1:0]    b_left;
    logic              pre_wrap;
    logic [PCNT_W-1:0] pre_cnt;
    logic              pre_run;
    logic              pre_plus1;

    swd_cfg_hold #(.A_W(A_W), .B_W(B_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .psel_in    (psel),
        .a_in       (a_val),
        .b_in       (b_val),
        .taken      (taken),
        .pend_psel  (pend_psel),
        .pend_a     (pend_a),
        .pend_b     (pend_b),
        .pend_new   (pend_new),
        .pend_legal (pend_legal)
    );

    always_comb begin
        pre_run   = (state == ST_SWALLOW) || (state == ST_MAIN);
        pre_plus1 = (state == ST_SWALLOW);
    end

    swd_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (pre_run),
        .plus1 (pre_plus1),
        .sel   (act_psel),
        .wrap  (pre_wrap),
        .cnt   (pre_cnt)
    );

    swd_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pre_wrap   (pre_wrap),
        .pend_psel  (pend_psel),
        .pend_a     (pend_a),
        .pend_b     (pend_b),
        .pend_new   (pend_new),
        .pend_legal (pend_legal),
        .state      (state),
        .act_psel   (act_psel),
        .a_left     (a_left),
        .b_left     (b_left),
        .taken      (taken),
        .div_out    (div_out),
        .cfg_err    (cfg_err)
    );

endmodule

// File: rtl/swd_checker.sv
module swd_checker
    import swd_pkg::*;
#(
    parameter int unsigned A_W = 6,
    parameter int unsigned B_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              div_out,
    input logic              cfg_err,
    input swd_state_e        state,
    input logic [PSEL_W-1:0] act_psel,
    input logic [A_W-1:0]    a_left,
    input logic [B_W-1:0]    b_left,
    input logic [PCNT_W-1:0] pre_cnt
);

    logic running;
    always_comb running = (state == ST_SWALLOW) || (state == ST_MAIN);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    p_fault_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err)) |-> !div_out);

    p_main_after_swallow_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAIN) |-> (a_left == '0));

    p_counts_ordered_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> (B_W'(a_left) <= b_left) && (b_left != '0));

    p_prescaler_bound_r2: assert property (@(posedge clk) disable iff (rst)
        running |-> (pre_cnt <= (PCNT_W'(PRE_BASE) << act_psel)));

    p_select_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && !div_out) |-> $stable(act_psel));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!div_out && !cfg_err));

endmodule

bind pswallow_div swd_checker #(.A_W(A_W), .B_W(B_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_out  (div_out),
    .cfg_err  (cfg_err),
    .state    (state),
    .act_psel (act_psel),
    .a_left   (a_left),
    .b_left   (b_left),
    .pre_cnt  (pre_cnt)
);

// File: tb/pswallow_div_bench.sv
module pswallow_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [1:0]  psel = '0;
    logic [5:0]  a_val = '0;
    logic [12:0] b_val = '0;
    logic        div_out;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pswallow_div u_pswallow_div (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .psel    (psel),
        .a_val   (a_val),
        .b_val   (b_val),
        .div_out (div_out),
        .cfg_err (cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int p, input int a, input int b);
        return b * (8 << p) + a;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        load = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Presents settings at a falling edge; they are captured at the next rising edge
    task automatic do_load(input int p, input int a, input int b);
        psel  = 2'(p);
        a_val = 6'(a);
        b_val = 13'(b);
        load  = 1'b1;
        @(negedge clk);
        load  = 1'b0;
    endtask

    task automatic wait_pulse(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_out);
    endtask

    // Falling edges from one pulse to the next, with the width check on the way
    task automatic next_gap(output int g);
        int c;
        @(negedge clk);
        check(!div_out, "R6 pulse wider than one cycle", int'(div_out), 0);
        wait_pulse(c);
        g = c + 1;
    endtask

    task automatic t_reset_state();
        bit seen_out = 0;
        bit seen_err = 0;
        do_reset();
        repeat (30) begin
            @(negedge clk);
            if (div_out) seen_out = 1;
            if (cfg_err) seen_err = 1;
        end
        check(!seen_out, "R8 div_out idle after reset", int'(seen_out), 0);
        check(!seen_err, "R8 cfg_err idle after reset", int'(seen_err), 0);
    endtask

    task automatic t_setting(input int p, input int a, input int b, input string tag);
        int n;
        int c;
        int g;
        n = ratio(p, a, b);
        do_reset();
        do_load(p, a, b);
        wait_pulse(c);
        check(c == n + 1, {tag, " R8 first pulse latency"}, c, n + 1);
        repeat (2) begin
            next_gap(g);
            check(g == n, {tag, " R1 period"}, g, n);
        end
    endtask

    task automatic t_modes();
        for (int p = 0; p < 4; p++) begin
            int b;
            int a;
            b = int'($urandom_range(40, 10));
            a = int'($urandom_range((b < 63) ? b : 63, 0));
            t_setting(p, a, b, "R2 mode");
        end
    endtask

    task automatic t_edges();
        t_setting(0, 0, 1, "R3 smallest ratio");
        t_setting(0, 0, 20, "R4 no swallow");
        t_setting(1, 20, 20, "R4 all swallow");
        t_setting(3, 63, 63, "R3 maximum A");
        t_setting(0, 5, 1000, "R3 large B");
    endtask

    task automatic t_midchange();
        int c;
        int g;
        do_reset();
        do_load(0, 3, 10);
        wait_pulse(c);
        do_load(1, 4, 6);
        wait_pulse(c);
        check(c + 1 == ratio(0, 3, 10), "R5 current period keeps old ratio", c + 1, ratio(0, 3, 10));
        next_gap(g);
        check(g == ratio(1, 4, 6), "R5 new ratio after wrap", g, ratio(1, 4, 6));
    endtask

    task automatic t_lastwins();
        int c;
        int g;
        do_reset();
        do_load(0, 0, 12);
        wait_pulse(c);
        do_load(2, 1, 3);
        do_load(1, 7, 9);
        wait_pulse(c);
        check(c + 2 == ratio(0, 0, 12), "R9 period in flight unchanged", c + 2, ratio(0, 0, 12));
        next_gap(g);
        check(g == ratio(1, 7, 9), "R9 last load applied", g, ratio(1, 7, 9));
    endtask

    task automatic t_fault();
        int  c;
        bit  seen_out = 0;
        bit  err_drop = 0;
        do_reset();
        do_load(0, 5, 3);
        @(negedge clk);
        check(cfg_err, "R7 flag for A greater than B", int'(cfg_err), 1);
        repeat (150) begin
            @(negedge clk);
            if (div_out) seen_out = 1;
            if (!cfg_err) err_drop = 1;
        end
        check(!seen_out, "R7 output silent in fault", int'(seen_out), 0);
        check(!err_drop, "R7 flag held in fault", int'(err_drop), 0);
        do_load(0, 0, 0);
        @(negedge clk);
        check(cfg_err, "R7 flag for zero B", int'(cfg_err), 1);
        do_load(2, 10, 12);
        @(negedge clk);
        check(!cfg_err, "R7 flag cleared by legal load", int'(cfg_err), 0);
        wait_pulse(c);
        check(c + 1 == ratio(2, 10, 12) + 1, "R7 restart latency", c + 1, ratio(2, 10, 12) + 1);
        do_load(0, 9, 2);
        wait_pulse(c);
        check(c + 1 == ratio(2, 10, 12), "R7 final period before fault", c + 1, ratio(2, 10, 12));
        check(cfg_err, "R7 flag with final pulse", int'(cfg_err), 1);
        seen_out = 0;
        repeat (100) begin
            @(negedge clk);
            if (div_out) seen_out = 1;
        end
        check(!seen_out, "R7 silent after mid-run fault", int'(seen_out), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_modes();
        t_edges();
        t_midchange();
        t_lastwins();
        t_fault();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule